// File: doc/BRIEF.md
# Eight-Bit Datapath ALU with Status Flag Generation

This block is the purely combinational arithmetic and logic unit of a small eight-bit RISC core. Each cycle it takes two operands, which the core supplies from two registers or from one register and an immediate, together with the current carry bit and a four-bit operation code. In the same cycle it returns an eight-bit result, the next values of six status flags, and a per-flag write-enable mask.

The status register sits outside this block. It loads only the flag bits whose mask bit is set and keeps the rest. The flags are carry, zero, negative, two's-complement overflow, sign (negative XOR overflow) and half-carry. Half-carry is the carry or borrow across the nibble boundary and is used for BCD correction. Single-operand operations ignore the second operand.

The block holds no state, so there are no states or transitions to list. The opcode selects one of four groups: arithmetic, logical, step (increment/decrement) and shift. Each group has a fixed rule for the flags and the mask.

Top module: `alu8_core`

## Requirements
- R1: Opcode encoding is 0 ADD, 1 ADDC, 2 SUB, 3 SUBC, 4 AND, 5 OR, 6 XOR, 7 INV, 8 NEG, 9 INC, 10 DEC, 11 SHL, 12 SHR, 13 ASR, 14 ROL, 15 ROR. Codes 0 to 3 return the sum or difference modulo 256, and carry_in takes part only for codes 1 and 3.
- R2: In the flag vector, bit 0 is C, bit 1 is Z, bit 2 is N, bit 3 is V, bit 4 is S and bit 5 is H, and the mask uses the same positions. For every opcode, Z is 1 exactly when the result is zero.
- R3: For every opcode, N equals result bit 7 and S equals N XOR V.
- R4: For codes 0 and 1, C is the unsigned carry out of bit 7, H is the carry out of bit 3, and V is set when the signed sum leaves the range -128 to 127.
- R5: For codes 2 and 3, C is set when opb plus the borrow exceeds opa as unsigned values. H is set when the low nibble of opb plus the borrow exceeds the low nibble of opa. V is set when the signed difference leaves the range -128 to 127.
- R6: Codes 4 to 7 return the bitwise AND, OR and XOR of the operands and the complement of opa. V is 0, the mask is 011110 (binary, bit 5 first), and the C output equals carry_in.
- R7: Code 8 returns 0 minus opa, with C set when opa is nonzero, H set when opa bits 3:0 are nonzero, and V set only for opa = 0x80.
- R8: Codes 9 and 10 return opa plus one and opa minus one modulo 256. V is set only for 0x7F and for 0x80 respectively, the mask is 011110, and the C output equals carry_in.
- R9: Codes 11 to 15 shift left or right. SHR shifts in 0 and ASR copies bit 7. ROL inserts carry_in at bit 0 and ROR inserts it at bit 7. C is the bit shifted out, V equals N XOR C, and the mask is 011111.
- R10: The mask is 111111 for codes 0 to 3 and 8. Whenever mask bit 5 is clear, the H output is 0.
- R11: For codes 7 to 15, opb has no effect on the result, the flags or the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 8 | First operand (destination register value) |
| opb | input | 8 | Second operand (register or immediate) |
| carry_in | input | 1 | Current carry flag |
| op | input | 4 | Operation code |
| result | output | 8 | Operation result |
| flags_nx | output | 6 | Next flag values {H,S,V,N,Z,C} |
| flags_we | output | 6 | Per-flag load enable for the status register |

## Verification
The block holds no state, so any fault in the group decode or in the nibble and sign logic shows up at the ports in the same evaluation that applies the stimulus. Examples are a wrong group choice, a mask with the wrong bits, or a carry that is not passed through. A wrong group decode appears as a wrong mask or as a carry that is not held. A fault in the half-carry or overflow logic shows only when the operands sit on a nibble or sign boundary, so those patterns are driven directly as well as at random.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBC = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_INV  = 4'd7,
        OP_NEG  = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_SHL  = 4'd11,
        OP_SHR  = 4'd12,
        OP_ASR  = 4'd13,
        OP_ROL  = 4'd14,
        OP_ROR  = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        GRP_ARITH,
        GRP_LOGIC,
        GRP_STEP,
        GRP_SHIFT
    } alu_grp_e;

    localparam int FLAG_W = 6;
    localparam int FC = 0;
    localparam int FZ = 1;
    localparam int FN = 2;
    localparam int FV = 3;
    localparam int FS = 4;
    localparam int FH = 5;

    localparam logic [FLAG_W-1:0] MASK_ALL   = 6'b111111;
    localparam logic [FLAG_W-1:0] MASK_ZNVS  = 6'b011110;
    localparam logic [FLAG_W-1:0] MASK_SHIFT = 6'b011111;

    function automatic alu_grp_e op_group(input alu_op_e op);
        alu_grp_e g;
        unique case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_NEG: g = GRP_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_INV:            g = GRP_LOGIC;
            OP_INC, OP_DEC:                           g = GRP_STEP;
            default:                                  g = GRP_SHIFT;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic         c_out,
    output logic         h_out,
    output logic         v_out
);
    localparam int HB = W / 2;
    localparam logic [HB:0] NIB_CARRY = (HB+1)'(1) << HB;

    logic [W-1:0] x, y;
    logic         bin, sub;
    logic [W:0]   full;
    logic [HB:0]  xl, yl;

    always_comb begin
        x   = a;
        y   = b;
        bin = 1'b0;
        sub = 1'b0;
        unique case (op)
            OP_ADDC: bin = ci;
            OP_SUB:  sub = 1'b1;
            OP_SUBC: begin sub = 1'b1; bin = ci; end
            OP_NEG:  begin sub = 1'b1; x = '0; y = a; end
            OP_INC:  y = W'(1);
            OP_DEC:  begin sub = 1'b1; y = W'(1); end
            default: ;
        endcase
    end

    always_comb begin
        if (sub)
            full = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, bin};
        else
            full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, bin};
        xl    = {1'b0, x[HB-1:0]};
        yl    = {1'b0, y[HB-1:0]} + {{HB{1'b0}}, bin};
        res   = full[W-1:0];
        c_out = full[W];
        if (sub) begin
            h_out = yl > xl;
            v_out = (x[W-1] != y[W-1]) && (full[W-1] != x[W-1]);
        end else begin
            h_out = (xl + yl) >= NIB_CARRY;
            v_out = (x[W-1] == y[W-1]) && (full[W-1] != x[W-1]);
        end
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic         c_out
);
    always_comb begin
        res   = '0;
        c_out = ci;
        unique case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_INV: res = ~a;
            OP_SHL: begin res = {a[W-2:0], 1'b0};    c_out = a[W-1]; end
            OP_SHR: begin res = {1'b0, a[W-1:1]};    c_out = a[0];   end
            OP_ASR: begin res = {a[W-1], a[W-1:1]};  c_out = a[0];   end
            OP_ROL: begin res = {a[W-2:0], ci};      c_out = a[W-1]; end
            OP_ROR: begin res = {ci, a[W-1:1]};      c_out = a[0];   end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]      res,
    input  alu_grp_e          grp,
    input  logic              ci,
    input  logic              ar_c,
    input  logic              ar_h,
    input  logic              ar_v,
    input  logic              sh_c,
    output logic [FLAG_W-1:0] flags,
    output logic [FLAG_W-1:0] we
);
    logic z, n, c, h, v;

    always_comb begin
        z = (res == '0);
        n = res[W-1];
        unique case (grp)
            GRP_ARITH: begin c = ar_c; h = ar_h; v = ar_v;   we = MASK_ALL;   end
            GRP_LOGIC: begin c = ci;   h = 1'b0; v = 1'b0;   we = MASK_ZNVS;  end
            GRP_STEP:  begin c = ci;   h = 1'b0; v = ar_v;   we = MASK_ZNVS;  end
            default:   begin c = sh_c; h = 1'b0; v = n ^ sh_c; we = MASK_SHIFT; end
        endcase
        flags     = '0;
        flags[FC] = c;
        flags[FZ] = z;
        flags[FN] = n;
        flags[FV] = v;
        flags[FS] = n ^ v;
        flags[FH] = h;
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]      opa,
    input  logic [W-1:0]      opb,
    input  logic              carry_in,
    input  logic [3:0]        op,
    output logic [W-1:0]      result,
    output logic [FLAG_W-1:0] flags_nx,
    output logic [FLAG_W-1:0] flags_we
);
    alu_op_e      op_e;
    alu_grp_e     grp;
    logic [W-1:0] ar_res, lg_res;
    logic         ar_c, ar_h, ar_v, sh_c;

    assign op_e = alu_op_e'(op);
    assign grp  = op_group(op_e);

    alu8_arith #(.W(W)) u_arith (
        .a(opa), .b(opb), .ci(carry_in), .op(op_e),
        .res(ar_res), .c_out(ar_c), .h_out(ar_h), .v_out(ar_v)
    );

    alu8_logic #(.W(W)) u_logic (
        .a(opa), .b(opb), .ci(carry_in), .op(op_e),
        .res(lg_res), .c_out(sh_c)
    );

    always_comb begin
        unique case (grp)
            GRP_ARITH, GRP_STEP: result = ar_res;
            default:             result = lg_res;
        endcase
    end

    alu8_flags #(.W(W)) u_flags (
        .res(result), .grp(grp), .ci(carry_in),
        .ar_c(ar_c), .ar_h(ar_h), .ar_v(ar_v), .sh_c(sh_c),
        .flags(flags_nx), .we(flags_we)
    );
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input logic [W-1:0]      opa,
    input logic              carry_in,
    input logic [3:0]        op,
    input logic [W-1:0]      result,
    input logic [FLAG_W-1:0] flags_nx,
    input logic [FLAG_W-1:0] flags_we
);
    always_comb begin
        // R2
        z_match_chk: assert (flags_nx[FZ] == (result == '0))
            else $error("zero flag disagrees with result");
        // R3
        sign_xor_chk: assert (flags_nx[FS] == (result[W-1] ^ flags_nx[FV]))
            else $error("sign flag is not N xor V");
        // R6
        logic_v_clear_chk: assert (!(op >= 4'd4 && op <= 4'd7) ||
                                   (!flags_nx[FV] && flags_we == MASK_ZNVS && flags_nx[FC] == carry_in))
            else $error("logical op flag rule broken");
        // R8
        step_keep_c_chk: assert (!(op == 4'd9 || op == 4'd10) ||
                                 (!flags_we[FC] && flags_nx[FC] == carry_in))
            else $error("step op touched carry");
        // R7
        neg_carry_chk: assert (op != 4'd8 || flags_nx[FC] == (opa != '0))
            else $error("negate carry wrong");
        // R10
        h_quiet_chk: assert (flags_we[FH] || !flags_nx[FH])
            else $error("half carry set while not loaded");
    end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
    .opa(opa), .carry_in(carry_in), .op(op),
    .result(result), .flags_nx(flags_nx), .flags_we(flags_we)
);

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opa = '0, opb = '0;
    logic       carry_in = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] result;
    logic [5:0] flags_nx, flags_we;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_core u0 (
        .opa(opa), .opb(opb), .carry_in(carry_in), .op(op),
        .result(result), .flags_nx(flags_nx), .flags_we(flags_we)
    );

    function automatic int sgn(input int x);
        return (x >= 128) ? x - 256 : x;
    endfunction

    function automatic string tag(input int o);
        if (o <= 1) return "R4";
        if (o <= 3) return "R5";
        if (o <= 7) return "R6";
        if (o == 8) return "R7";
        if (o <= 10) return "R8";
        return "R9";
    endfunction

    // Behavioural reference built from the requirements (R1..R10).
    task automatic model(input int a, input int b, input int ci, input int o,
                         output int r, output int f, output int m);
        int c, h, v, n, z, t, st;
        c = ci; h = 0; v = 0; m = 'b011110;
        case (o)
            0, 1: begin
                t = (o == 1) ? ci : 0;
                r = (a + b + t) % 256; c = (a + b + t) > 255;
                h = ((a % 16) + (b % 16) + t) > 15;
                st = sgn(a) + sgn(b) + t; v = (st > 127) || (st < -128);
                m = 'b111111;
            end
            2, 3: begin
                t = (o == 3) ? ci : 0;
                r = (a - b - t + 512) % 256; c = (b + t) > a;
                h = ((b % 16) + t) > (a % 16);
                st = sgn(a) - sgn(b) - t; v = (st > 127) || (st < -128);
                m = 'b111111;
            end
            4: r = a & b;
            5: r = a | b;
            6: r = a ^ b;
            7: r = 255 - a;
            8: begin r = (256 - a) % 256; c = a != 0; h = (a % 16) != 0; v = a == 128; m = 'b111111; end
            9: begin r = (a + 1) % 256; v = a == 127; end
            10: begin r = (a + 255) % 256; v = a == 128; end
            default: begin
                m = 'b011111;
                case (o)
                    11: begin r = (a * 2) % 256; c = a / 128; end
                    12: begin r = a / 2; c = a % 2; end
                    13: begin r = a / 2 + (a / 128) * 128; c = a % 2; end
                    14: begin r = (a * 2) % 256 + ci; c = a / 128; end
                    default: begin r = a / 2 + ci * 128; c = a % 2; end
                endcase
            end
        endcase
        n = r / 128; z = (r == 0);
        if (m == 'b011111) v = n ^ c;
        f = c + 2*z + 4*n + 8*v + 16*(n ^ v) + 32*h;
    endtask

    task automatic chk(input int a, input int b, input int ci, input int o);
        int er, ef, em;
        @(posedge clk);
        opa = 8'(a); opb = 8'(b); carry_in = ci[0]; op = 4'(o);
        @(negedge clk);
        model(a, b, ci, o, er, ef, em);
        checks++;
        if (result !== 8'(er) || flags_nx !== 6'(ef) || flags_we !== 6'(em)) begin
            failures++;
            $display("FAIL %s (R1 R2 R3 R10) op=%0d a=%02h b=%02h ci=%0d: got res=%02h fl=%06b we=%06b exp res=%02h fl=%06b we=%06b",
                     tag(o), o, a, b, ci, result, flags_nx, flags_we, er, 6'(ef), 6'(em));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R2: idle state, ADD of zeros gives zero result with Z set
        @(negedge clk);
        checks++;
        if (result !== 8'h00 || flags_nx !== 6'b000010) begin
            failures++;
            $display("FAIL R2 reset: res=%02h fl=%06b exp res=00 fl=000010", result, flags_nx);
        end
        // R4 add corners
        chk(8'h7F, 8'h01, 0, 0); chk(8'hFF, 8'h01, 0, 0); chk(8'h0F, 8'h01, 0, 0);
        chk(8'h80, 8'h80, 1, 0); chk(8'hFF, 8'h00, 1, 1); chk(8'h7F, 8'h00, 1, 1);
        // R5 subtract corners
        chk(8'h00, 8'h01, 0, 2); chk(8'h80, 8'h01, 0, 2); chk(8'h10, 8'h01, 0, 2);
        chk(8'h05, 8'h05, 1, 3); chk(8'h05, 8'h05, 0, 3); chk(8'h00, 8'hFF, 1, 3);
        // R6 logical
        chk(8'hF0, 8'h3C, 1, 4); chk(8'hF0, 8'h0F, 0, 4); chk(8'h80, 8'h01, 1, 5);
        chk(8'hAA, 8'hAA, 1, 6); chk(8'hFF, 8'h00, 1, 7); chk(8'h00, 8'h00, 0, 7);
        // R7 negate
        chk(8'h00, 8'h12, 0, 8); chk(8'h80, 8'h00, 0, 8); chk(8'h01, 8'h00, 1, 8); chk(8'h10, 8'h00, 0, 8);
        // R8 step
        chk(8'h7F, 8'h00, 1, 9); chk(8'hFF, 8'h00, 0, 9); chk(8'h80, 8'h00, 1, 10); chk(8'h00, 8'h00, 0, 10);
        // R9 shifts and rotates
        for (int o = 11; o <= 15; o++) begin
            chk(8'h81, 8'h00, 0, o); chk(8'h81, 8'h00, 1, o); chk(8'h40, 8'h00, 1, o); chk(8'h01, 8'h00, 0, o);
        end
        // R1..R10 random patterns
        for (int i = 0; i < 3000; i++)
            chk(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                int'($urandom_range(0, 1)), int'($urandom_range(0, 15)));
        // R11: opb ignored by single-operand codes
        for (int o = 7; o <= 15; o++) begin
            logic [7:0] r0;
            logic [5:0] f0, m0;
            @(posedge clk); opa = 8'h96; opb = 8'h00; carry_in = 1'b1; op = 4'(o);
            @(negedge clk); r0 = result; f0 = flags_nx; m0 = flags_we;
            @(posedge clk); opb = 8'hFF;
            @(negedge clk);
            checks++;
            if (result !== r0 || flags_nx !== f0 || flags_we !== m0) begin
                failures++;
                $display("FAIL R11 op=%0d: got %02h/%06b/%06b exp %02h/%06b/%06b",
                         o, result, flags_nx, flags_we, r0, f0, m0);
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule